// File: doc/BRIEF.md
# Up-Down Timer with Center-Aligned Counting

This block is a free-running timer counter with a small configuration register that selects how it counts. In edge-aligned mode the counter moves in one direction only, set by a software direction bit, and wraps at the ends of the range set by a reload value. In the three center-aligned modes the counter sweeps up to the reload value and back down to zero over and over. Each mode chooses which sweeps may raise the compare flag: the falling sweep, the rising sweep, or both. While center-aligned counting is active, the hardware owns the direction bit. Software writes to it are dropped, and reading it returns the direction of the current sweep.

A sweep state machine holds the counting direction in four states. ST_EDGE_UP and ST_EDGE_DN are the two edge-aligned directions. ST_CTR_UP and ST_CTR_DN are the rising and falling center-aligned sweeps. A configuration write that selects edge-aligned mode moves the machine to ST_EDGE_UP or ST_EDGE_DN, according to the written direction bit. A write that switches to a different center-aligned mode moves it to ST_CTR_UP. While counting, ST_CTR_UP goes to ST_CTR_DN at the reload value, and ST_CTR_DN goes to ST_CTR_UP at zero. The edge-aligned states keep their state while counting. Each wrap or turning point produces a one-cycle update event.

The compare flag stays set until software clears it. The counter, the flag and the update event move only while the count enable is high. All outputs are registered.

Top module: `updown_timer`

## Requirements
- R1: After synchronous reset the count is 0, the direction status reads 0 (up), the compare flag is 0, the update event is 0, and the mode field is 00 (edge-aligned).
- R2: In edge-aligned mode (mode 00) with direction 0, each enabled cycle adds one to the count. From the reload value the count goes to 0, and the update output is high for the one cycle after that wrap.
- R3: In edge-aligned mode with direction 1, each enabled cycle subtracts one from the count. From 0 the count goes to the reload value, with a one-cycle update pulse. The direction status reads 1.
- R4: While the count enable is low, the count holds its value, the update output stays low and the compare flag is not set.
- R5: In center-aligned modes (mode 01, 10 or 11) the count runs 0,1,…,reload,reload-1,…,0,1,… The sweep turns from up to down on the cycle the count is at the reload value, and from down to up on the cycle it is at 0. The update output pulses and the direction status (0 up, 1 down) flips on the cycle after each turning point.
- R6: A configuration write that selects a center-aligned mode ignores the written direction bit. The direction status keeps showing the live sweep direction.
- R7: In mode 01, an enabled cycle with count equal to the compare value sets the flag only during the down sweep.
- R8: In mode 10, an enabled cycle with count equal to the compare value sets the flag only during the up sweep.
- R9: In mode 11, such a match sets the flag in either sweep.
- R10: The flag stays set until a cycle with the clear input high. When a set and a clear fall in the same cycle, the flag ends up set.
- R11: A configuration write that changes the mode to a center-aligned one restarts the sweep direction at up.
- R12: In edge-aligned mode, an enabled cycle with count equal to the compare value sets the flag in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable |
| reload | input | WIDTH | Top of the counting range |
| compare | input | WIDTH | Compare value |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Mode field write data: 00 edge, 01/10/11 center modes 1/2/3 |
| cfg_dir | input | 1 | Direction bit write data: 0 up, 1 down |
| dir_o | output | 1 | Direction status: 0 up, 1 down |
| count_o | output | WIDTH | Current count |
| cmp_flag_o | output | 1 | Sticky compare-match flag |
| flag_clr | input | 1 | Clears the compare flag |
| update_o | output | 1 | One-cycle pulse after a wrap or turning point |

## Verification
The bench aims at the turning points. A design that repeats the reload value or zero at a turn, or flips the direction one cycle late, gives the wrong count sequence or drops the update pulse next to the direction change. Matches at the compare value are driven in both sweeps for each center-aligned mode. Gating on the wrong sweep sets or misses the flag during the stretch that only one sweep covers. Directed cases also cover a direction write during center-aligned mode, which must not reach the status. They cover a mode change made mid-fall, which must restart the sweep upward. They cover a clear that lands on a match cycle, where the flag must end up set.

// File: rtl/updown_timer_pkg.sv
package updown_timer_pkg;

    typedef enum logic [1:0] {
        MODE_EDGE = 2'b00,
        MODE_CTR1 = 2'b01,
        MODE_CTR2 = 2'b10,
        MODE_CTR3 = 2'b11
    } cnt_mode_e;

    typedef enum logic [1:0] {
        ST_EDGE_UP = 2'b00,
        ST_EDGE_DN = 2'b01,
        ST_CTR_UP  = 2'b10,
        ST_CTR_DN  = 2'b11
    } sweep_e;

endpackage

// File: rtl/ut_cfg_reg.sv
module ut_cfg_reg
    import updown_timer_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cfg_we,
    input  logic [1:0] cfg_mode,
    output cnt_mode_e mode_q,
    output logic      mode_chg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_EDGE;
        end else if (cfg_we) begin
            mode_q <= cnt_mode_e'(cfg_mode);
        end
    end

    always_comb begin
        mode_chg = cfg_we && (cnt_mode_e'(cfg_mode) != mode_q);
    end

endmodule

// File: rtl/ut_sweep_fsm.sv
module ut_sweep_fsm
    import updown_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cnt_en,
    input  logic       cfg_we,
    input  logic [1:0] cfg_mode,
    input  logic       cfg_dir,
    input  logic       mode_chg,
    input  logic       at_top,
    input  logic       at_bot,
    output sweep_e     state_q,
    output logic       dir,
    output logic       update_q
);

    sweep_e state_d;
    logic   turn;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EDGE_UP;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (cfg_we && cnt_mode_e'(cfg_mode) == MODE_EDGE) begin
            state_d = cfg_dir ? ST_EDGE_DN : ST_EDGE_UP;
        end else if (mode_chg) begin
            state_d = ST_CTR_UP;
        end else if (cnt_en) begin
            unique case (state_q)
                ST_EDGE_UP: state_d = ST_EDGE_UP;
                ST_EDGE_DN: state_d = ST_EDGE_DN;
                ST_CTR_UP:  state_d = at_top ? ST_CTR_DN : ST_CTR_UP;
                ST_CTR_DN:  state_d = at_bot ? ST_CTR_UP : ST_CTR_DN;
            endcase
        end
    end

    // outputs
    always_comb begin
        turn = 1'b0;
        dir  = 1'b0;
        unique case (state_q)
            ST_EDGE_UP: begin dir = 1'b0; turn = cnt_en && at_top; end
            ST_EDGE_DN: begin dir = 1'b1; turn = cnt_en && at_bot; end
            ST_CTR_UP:  begin dir = 1'b0; turn = cnt_en && at_top; end
            ST_CTR_DN:  begin dir = 1'b1; turn = cnt_en && at_bot; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            update_q <= 1'b0;
        end else begin
            update_q <= turn;
        end
    end

endmodule

// File: rtl/ut_counter.sv
module ut_counter
    import updown_timer_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  sweep_e           state_q,
    input  logic [WIDTH-1:0] reload,
    output logic [WIDTH-1:0] count_q,
    output logic             at_top,
    output logic             at_bot
);

    localparam logic [WIDTH-1:0] ZERO = '0;
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

    logic [WIDTH-1:0] count_d;

    always_comb begin
        at_top = (count_q >= reload);
        at_bot = (count_q == ZERO);
    end

    always_comb begin
        count_d = count_q;
        if (cnt_en) begin
            unique case (state_q)
                ST_EDGE_UP: count_d = at_top ? ZERO : count_q + ONE;
                ST_EDGE_DN: count_d = at_bot ? reload : count_q - ONE;
                ST_CTR_UP:  count_d = at_top ? (at_bot ? ZERO : count_q - ONE)
                                             : count_q + ONE;
                ST_CTR_DN:  count_d = at_bot ? ((reload == ZERO) ? ZERO : ONE)
                                             : count_q - ONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= ZERO;
        end else begin
            count_q <= count_d;
        end
    end

endmodule

// File: rtl/ut_cmp_flag.sv
module ut_cmp_flag
    import updown_timer_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic [WIDTH-1:0] count_q,
    input  logic [WIDTH-1:0] compare,
    input  sweep_e           state_q,
    input  cnt_mode_e        mode_q,
    input  logic             flag_clr,
    output logic             flag_q
);

    logic match;
    logic sweep_ok;
    logic set;

    always_comb begin
        match    = cnt_en && (count_q == compare);
        sweep_ok = 1'b0;
        unique case (mode_q)
            MODE_EDGE: sweep_ok = 1'b1;
            MODE_CTR1: sweep_ok = (state_q == ST_CTR_DN);
            MODE_CTR2: sweep_ok = (state_q == ST_CTR_UP);
            MODE_CTR3: sweep_ok = 1'b1;
        endcase
        set = match && sweep_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= set || (flag_q && !flag_clr);
        end
    end

endmodule

// File: rtl/updown_timer.sv
module updown_timer
    import updown_timer_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic [WIDTH-1:0] reload,
    input  logic [WIDTH-1:0] compare,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_dir,
    output logic             dir_o,
    output logic [WIDTH-1:0] count_o,
    output logic             cmp_flag_o,
    input  logic             flag_clr,
    output logic             update_o
);

    cnt_mode_e mode_q;
    logic      mode_chg;
    sweep_e    state_q;
    logic      at_top;
    logic      at_bot;

    ut_cfg_reg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_mode (cfg_mode),
        .mode_q   (mode_q),
        .mode_chg (mode_chg)
    );

    ut_sweep_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .cnt_en   (cnt_en),
        .cfg_we   (cfg_we),
        .cfg_mode (cfg_mode),
        .cfg_dir  (cfg_dir),
        .mode_chg (mode_chg),
        .at_top   (at_top),
        .at_bot   (at_bot),
        .state_q  (state_q),
        .dir      (dir_o),
        .update_q (update_o)
    );

    ut_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .cnt_en  (cnt_en),
        .state_q (state_q),
        .reload  (reload),
        .count_q (count_o),
        .at_top  (at_top),
        .at_bot  (at_bot)
    );

    ut_cmp_flag #(.WIDTH(WIDTH)) u_flag (
        .clk      (clk),
        .rst      (rst),
        .cnt_en   (cnt_en),
        .count_q  (count_o),
        .compare  (compare),
        .state_q  (state_q),
        .mode_q   (mode_q),
        .flag_clr (flag_clr),
        .flag_q   (cmp_flag_o)
    );

endmodule

// File: rtl/updown_timer_chk.sv
module updown_timer_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cnt_en,
    input logic [WIDTH-1:0] reload,
    input logic             cfg_we,
    input logic [1:0]       cfg_mode,
    input logic             dir_o,
    input logic [WIDTH-1:0] count_o,
    input logic             cmp_flag_o,
    input logic             flag_clr,
    input logic             update_o
);

    logic [1:0] seen_mode;
    logic       center;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_mode <= 2'b00;
        end else if (cfg_we) begin
            seen_mode <= cfg_mode;
        end
    end

    assign center = (seen_mode != 2'b00);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (count_o == '0 && !dir_o && !cmp_flag_o && !update_o));

    p_edge_up_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (!center && !dir_o && cnt_en && !cfg_we && count_o == reload)
        |=> (count_o == '0 && update_o));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en) |=> ($stable(count_o) && !update_o));

    p_dir_flip_r5: assert property (@(posedge clk) disable iff (rst)
        (center && !cfg_we) |=> ((dir_o != $past(dir_o)) == update_o));

    p_dir_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_mode != 2'b00 && cfg_mode == seen_mode && !cnt_en)
        |=> $stable(dir_o));

    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (cmp_flag_o && !flag_clr) |=> cmp_flag_o);

    p_mode_change_up_r11: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_mode != 2'b00 && cfg_mode != seen_mode) |=> !dir_o);

endmodule

bind updown_timer updown_timer_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cnt_en     (cnt_en),
    .reload     (reload),
    .cfg_we     (cfg_we),
    .cfg_mode   (cfg_mode),
    .dir_o      (dir_o),
    .count_o    (count_o),
    .cmp_flag_o (cmp_flag_o),
    .flag_clr   (flag_clr),
    .update_o   (update_o)
);

// File: tb/updown_timer_bench.sv
`timescale 1ns/1ps
module updown_timer_bench;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cnt_en = 1'b0;
    logic [W-1:0] reload = '0;
    logic [W-1:0] compare = '0;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_mode = 2'b00;
    logic         cfg_dir = 1'b0;
    logic         flag_clr = 1'b0;
    logic         dir_o;
    logic [W-1:0] count_o;
    logic         cmp_flag_o;
    logic         update_o;

    int n_checks = 0;
    int n_fails  = 0;

    // bench-side expectation
    int m_cnt  = 0;
    bit m_dn   = 0;
    int m_mode = 0;
    bit m_flag = 0;
    bit m_upd  = 0;

    always #5 clk = ~clk;

    updown_timer #(.WIDTH(W)) u_updown_timer (
        .clk        (clk),
        .rst        (rst),
        .cnt_en     (cnt_en),
        .reload     (reload),
        .compare    (compare),
        .cfg_we     (cfg_we),
        .cfg_mode   (cfg_mode),
        .cfg_dir    (cfg_dir),
        .dir_o      (dir_o),
        .count_o    (count_o),
        .cmp_flag_o (cmp_flag_o),
        .flag_clr   (flag_clr),
        .update_o   (update_o)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, "count", int'(count_o), m_cnt);
        check(tag, "dir", int'(dir_o), int'(m_dn));
        check(tag, "flag", int'(cmp_flag_o), int'(m_flag));
        check(tag, "update", int'(update_o), int'(m_upd));
    endtask

    // one clock with the given enable and clear; called at a falling edge
    task automatic step(input bit en, input bit clr, input string tag);
        bit set;
        bit center;
        int rel;
        cnt_en   = en;
        flag_clr = clr;
        @(posedge clk);
        rel    = int'(reload);
        set    = 0;
        m_upd  = 0;
        center = (m_mode != 0);
        if (en) begin
            if (m_cnt == int'(compare))
                set = !center || m_mode == 3 || (m_mode == 1 && m_dn) || (m_mode == 2 && !m_dn);
            if (!center) begin
                if (!m_dn) begin
                    if (m_cnt == rel) begin m_cnt = 0; m_upd = 1; end
                    else m_cnt = m_cnt + 1;
                end else begin
                    if (m_cnt == 0) begin m_cnt = rel; m_upd = 1; end
                    else m_cnt = m_cnt - 1;
                end
            end else begin
                if (!m_dn) begin
                    if (m_cnt == rel) begin m_dn = 1; m_upd = 1; m_cnt = (rel == 0) ? 0 : rel - 1; end
                    else m_cnt = m_cnt + 1;
                end else begin
                    if (m_cnt == 0) begin m_dn = 0; m_upd = 1; m_cnt = (rel == 0) ? 0 : 1; end
                    else m_cnt = m_cnt - 1;
                end
            end
        end
        m_flag = set || (m_flag && !clr);
        @(negedge clk);
        cnt_en   = 0;
        flag_clr = 0;
        compare_all(tag);
    endtask

    task automatic cfg(input int mode, input bit dirv, input string tag);
        cfg_we   = 1;
        cfg_mode = 2'(mode);
        cfg_dir  = dirv;
        @(posedge clk);
        if (mode == 0) m_dn = dirv;
        else if (mode != m_mode) m_dn = 0;
        m_mode = mode;
        m_upd  = 0;
        @(negedge clk);
        cfg_we  = 0;
        cfg_dir = 0;
        compare_all(tag);
    endtask

    task automatic t_reset();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        m_cnt = 0; m_dn = 0; m_mode = 0; m_flag = 0; m_upd = 0;
        compare_all("R1");
    endtask

    task automatic t_edge_up();
        reload = 16'd5; compare = 16'd9;
        for (int i = 0; i < 14; i++) step(1, 0, "R2");
    endtask

    task automatic t_hold();
        for (int i = 0; i < 3; i++) step(0, 0, "R4");
        compare = count_o;   // would match if the idle cycles counted
        for (int i = 0; i < 2; i++) step(0, 0, "R4");
        compare = 16'd9;
    endtask

    task automatic t_edge_down();
        cfg(0, 1, "R3");
        for (int i = 0; i < 14; i++) step(1, 0, "R3");
    endtask

    task automatic t_edge_cmp();
        compare = 16'd3;
        step(0, 1, "R12");
        for (int i = 0; i < 7; i++) step(1, 0, "R12");
        cfg(0, 0, "R12");
        step(0, 1, "R12");
        for (int i = 0; i < 7; i++) step(1, 0, "R12");
    endtask

    task automatic t_center();
        reload = 16'd4; compare = 16'd9;
        cfg(3, 1, "R11");
        for (int i = 0; i < 20; i++) step(1, 0, "R5");
    endtask

    task automatic t_dir_ignored();
        for (int i = 0; i < 10 && !m_dn; i++) step(1, 0, "R5");
        cfg(3, 0, "R6");
        step(1, 0, "R6");
        for (int i = 0; i < 10 && m_dn; i++) step(1, 0, "R5");
        cfg(3, 1, "R6");
        step(1, 0, "R6");
    endtask

    task automatic t_mode_change_mid_fall();
        for (int i = 0; i < 10 && !m_dn; i++) step(1, 0, "R5");
        cfg(1, 0, "R11");
        step(1, 0, "R11");
    endtask

    task automatic t_mode1();
        compare = 16'd2;
        step(0, 1, "R7");
        for (int i = 0; i < 18; i++) begin
            step(1, 0, "R7");
            if (m_flag) step(0, 1, "R7");
        end
    endtask

    task automatic t_mode2();
        cfg(2, 0, "R8");
        compare = 16'd2;
        step(0, 1, "R8");
        for (int i = 0; i < 18; i++) begin
            step(1, 0, "R8");
            if (m_flag) step(0, 1, "R8");
        end
    endtask

    task automatic t_mode3();
        cfg(3, 0, "R9");
        compare = 16'd1;
        step(0, 1, "R9");
        for (int i = 0; i < 18; i++) begin
            step(1, 0, "R9");
            if (m_flag) step(0, 1, "R9");
        end
    endtask

    task automatic t_flag();
        cfg(0, 0, "R10");
        reload = 16'd6; compare = 16'd4;
        for (int i = 0; i < 10 && !m_flag; i++) step(1, 0, "R10");
        step(0, 0, "R10");
        step(1, 0, "R10");
        step(0, 1, "R10");
        for (int i = 0; i < 10 && m_cnt != 4; i++) step(1, 0, "R10");
        step(1, 1, "R10");   // match and clear together
        step(1, 1, "R10");   // clear alone
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_edge_up();
        t_hold();
        t_edge_down();
        t_edge_cmp();
        t_center();
        t_dir_ignored();
        t_mode_change_mid_fall();
        t_mode1();
        t_mode2();
        t_mode3();
        t_flag();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #1_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule